// File: doc/BRIEF.md
# Receive Chunk Framer with Status Footer

This block sits on the device side of a full-duplex serial link that moves Ethernet traffic in fixed-size chunks. Each time the host opens a transmit chunk by sending a data header, the framer answers with one receive chunk. The chunk is a payload of `PAY_BYTES` bytes followed by a 32-bit footer. The framer pulls received frame bytes from an upstream byte stream into the payload. It then describes the payload in the footer: where a frame starts and ends, whether it must be dropped, how many receive chunks are still waiting, how many transmit credits are free, three status flags and an odd parity bit.

The serial shifter drives `out_next` once per byte it takes. `out_data` holds the byte that pulse consumes. The upstream buffer is expected to hold complete frames, so once a frame has started its bytes stay available until its last byte. The block also drives an active-high interrupt. The interrupt fires when a quantity that the last footer reported as zero becomes nonzero, and the next data header clears it.

Top module: `rx_chunk_framer`

## Requirements
- R1: A `hdr_valid` pulse while `chunk_busy` is low starts a chunk. Exactly `PAY_BYTES`+4 `out_next` pulses then drain it: first the payload, then the footer with its most significant byte first. `chunk_busy` drops after the last footer byte.
- R2: Payload bytes carry the input frame bytes in order, and every unused payload byte is 0x00. Footer bit 21 is 1 exactly when the payload holds at least one frame byte.
- R3: When `hdr_norx` is set with the header, footer bit 21 is 0, the payload is all zero and no input byte is consumed (`in_ready` stays low for the whole chunk).
- R4: A frame may start only at a payload byte index that is a multiple of 4. A chunk holds at most one start, and no start follows an end in the same chunk. Bit 20 flags the start and bits 19..16 carry its word index. Both are zero when there is no start.
- R5: Bit 14 flags that the last byte of a frame is in the payload, and bits 13..8 give that byte's index. Both are zero when there is no end.
- R6: Bit 15 equals `in_drop` as seen with the frame's last byte, and is zero in any chunk whose bit 14 is clear.
- R7: Bits 28..24 equal min(`rx_pend_chunks`, 31). Bits 5..1 equal min(`tx_free_chunks`, 31). Both are sampled when the first footer byte is consumed.
- R8: Bit 31 equals `ext_status`, bit 30 equals `hdr_perr` given with this chunk's header, and bit 29 equals `cfg_sync`. Bits 23..22 and 7..6 are zero. Bit 0 makes the footer's count of ones odd.
- R9: `irq` rises one clock after `ext_status`, the pending count or the credit count turns nonzero while the last footer reported it zero. Reset counts as a footer that reported all three as zero. Each such footer arms at most one rise per quantity. `irq` is low one clock after `hdr_valid`.
- R10: After reset, `irq`, `chunk_busy` and `in_ready` are low and `out_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Pulse: a data header has arrived |
| hdr_norx | input | 1 | Host refuses receive data in this chunk |
| hdr_perr | input | 1 | The header arrived with bad parity |
| out_next | input | 1 | Shifter consumes `out_data` this cycle |
| out_data | output | 8 | Current chunk byte |
| chunk_busy | output | 1 | A chunk is in progress |
| in_valid | input | 1 | Upstream frame byte available |
| in_data | input | 8 | Upstream frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_drop | input | 1 | Frame must be dropped (meaningful with `in_eof`) |
| in_ready | output | 1 | Upstream byte consumed this cycle |
| rx_pend_chunks | input | CNT_W | Receive chunks waiting beyond the current one |
| tx_free_chunks | input | CNT_W | Free transmit chunk buffers |
| ext_status | input | 1 | An unmasked status bit is set |
| cfg_sync | input | 1 | Configuration-synchronised flag |
| irq | output | 1 | Interrupt to the host, active high |

## Verification
`out_data` and `in_ready` are combinational in the current byte position and the inputs. The bench drives each `out_next` pulse after a falling edge, samples both outputs one time unit later, and lets the position advance at the next rising edge. Offsets, drop and valid flags taken from the last payload byte show up in the footer, which the bench reads from the bytes it collects across the whole chunk. The interrupt is registered, so the bench changes a count after a falling edge and reads `irq` at the next falling edge, one rising edge later. It reads the clear the same way, at the first falling edge after the chunk the header opened.

// File: rtl/rx_chunk_framer.sv
module rx_chunk_framer #(
  parameter int PAY_BYTES = 64,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  input  logic             hdr_norx,
  input  logic             hdr_perr,
  input  logic             out_next,
  output logic [7:0]       out_data,
  output logic             chunk_busy,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_drop,
  output logic             in_ready,
  input  logic [CNT_W-1:0] rx_pend_chunks,
  input  logic [CNT_W-1:0] tx_free_chunks,
  input  logic             ext_status,
  input  logic             cfg_sync,
  output logic             irq
);
  localparam int CHUNK_BYTES = PAY_BYTES + 4;
  localparam int POS_W       = $clog2(CHUNK_BYTES);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(31);

  logic             busy, dv_en, hdrb_q, in_frame;
  logic             dv_q, sv_q, ev_q, fd_q;
  logic [3:0]       swo_q;
  logic [5:0]       ebo_q;
  logic [POS_W-1:0] pos;
  logic [31:0]      foot_q;
  logic [2:0]       arm;

  wire [7:0]       pos8    = 8'(pos);
  wire             in_pay  = busy && (pos < POS_W'(PAY_BYTES));
  wire [POS_W-1:0] fsel    = pos - POS_W'(PAY_BYTES);
  wire             at_foot = busy && (pos == POS_W'(PAY_BYTES));
  wire             foot_ld = at_foot && out_next;

  wire start_ok = dv_en && !sv_q && !ev_q && !in_frame && (pos[1:0] == 2'b00)
                  && in_valid && in_sof;
  wire carry    = in_pay && dv_en && in_valid && (in_frame || start_ok);
  wire take     = carry && out_next;

  wire [4:0] rca_f = (rx_pend_chunks > SAT) ? 5'd31 : rx_pend_chunks[4:0];
  wire [4:0] txc_f = (tx_free_chunks > SAT) ? 5'd31 : tx_free_chunks[4:0];

  wire [31:1] foot_hi = {ext_status, hdrb_q, cfg_sync, rca_f, 2'b00, dv_q, sv_q,
                         swo_q, fd_q, ev_q, ebo_q, 2'b00, txc_f};
  wire [31:0] foot_c  = {foot_hi, ~^foot_hi};

  wire [2:0] nz   = {ext_status, |rca_f, |txc_f};
  wire [2:0] hit  = arm & nz;
  wire       fire = |hit && !foot_ld;

  assign in_ready   = take;
  assign chunk_busy = busy;

  always_comb begin
    if (in_pay)
      out_data = carry ? in_data : 8'h00;
    else if (!busy)
      out_data = 8'h00;
    else begin
      case (fsel[1:0])
        2'd0:    out_data = foot_c[31:24];
        2'd1:    out_data = foot_q[23:16];
        2'd2:    out_data = foot_q[15:8];
        default: out_data = foot_q[7:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pos <= '0; dv_en <= 1'b0; hdrb_q <= 1'b0; in_frame <= 1'b0;
      dv_q <= 1'b0; sv_q <= 1'b0; ev_q <= 1'b0; fd_q <= 1'b0;
      swo_q <= '0; ebo_q <= '0; foot_q <= '0;
    end else if (hdr_valid && !busy) begin
      busy <= 1'b1; pos <= '0; dv_en <= !hdr_norx; hdrb_q <= hdr_perr;
      dv_q <= 1'b0; sv_q <= 1'b0; ev_q <= 1'b0; fd_q <= 1'b0;
      swo_q <= '0; ebo_q <= '0;
    end else if (busy && out_next) begin
      pos <= pos + 1'b1;
      if (pos == POS_W'(CHUNK_BYTES - 1)) busy <= 1'b0;
      if (foot_ld) foot_q <= foot_c;
      if (take) begin
        dv_q <= 1'b1;
        if (start_ok) begin
          sv_q <= 1'b1; swo_q <= pos8[5:2]; in_frame <= 1'b1;
        end
        if (in_eof) begin
          ev_q <= 1'b1; ebo_q <= pos8[5:0]; fd_q <= in_drop; in_frame <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm <= 3'b111;
      irq <= 1'b0;
    end else begin
      if (foot_ld)   arm <= ~nz;
      else if (fire) arm <= arm & ~nz;
      if (hdr_valid) irq <= 1'b0;
      else if (fire) irq <= 1'b1;
    end
  end
endmodule

module rx_chunk_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic        irq,
  input logic        in_ready,
  input logic        in_valid,
  input logic        in_sof,
  input logic        chunk_busy,
  input logic        dv_en,
  input logic        in_frame,
  input logic [1:0]  pos_lo,
  input logic [31:0] foot_q,
  input logic        foot_ld
);
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !irq);
  // R1
  ready_in_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (chunk_busy && in_valid));
  // R3
  norx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_busy && !dv_en) |-> !in_ready);
  // R4
  word_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_sof && !in_frame) |-> (pos_lo == 2'b00));
  // R8
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    foot_ld |=> (^foot_q == 1'b1));
endmodule

bind rx_chunk_framer rx_chunk_framer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .irq(irq),
  .in_ready(in_ready), .in_valid(in_valid), .in_sof(in_sof),
  .chunk_busy(chunk_busy), .dv_en(dv_en), .in_frame(in_frame),
  .pos_lo(pos[1:0]), .foot_q(foot_q), .foot_ld(foot_ld)
);

// File: tb/rx_chunk_framer_tb.sv
module rx_chunk_framer_tb_top;
  localparam int PAY = 16;
  localparam int CW  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 0, hdr_norx = 0, hdr_perr = 0, out_next = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_drop = 0;
  logic [7:0] in_data = 8'h00;
  logic [CW-1:0] rx_pend = '0, tx_free = '0;
  logic ext_st = 0, sync_f = 0;
  logic [7:0] out_data;
  logic chunk_busy, in_ready, irq;

  always #5 clk = ~clk;

  rx_chunk_framer #(.PAY_BYTES(PAY), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_norx(hdr_norx),
    .hdr_perr(hdr_perr), .out_next(out_next), .out_data(out_data),
    .chunk_busy(chunk_busy), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_drop(in_drop), .in_ready(in_ready),
    .rx_pend_chunks(rx_pend), .tx_free_chunks(tx_free), .ext_status(ext_st),
    .cfg_sync(sync_f), .irq(irq));

  int nerr = 0, nchk = 0;
  bit done = 0;

  int q_len[0:127];
  bit q_drop[0:127];
  int q_n = 0, q_h = 0, q_i = 0;
  int avail_from = 0;
  int cons;
  logic [7:0] cb[0:PAY+3];
  logic [31:0] foot;

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(int f, int j);
    return 8'(f * 37 + j * 5 + 1);
  endfunction

  function automatic int sat(int x);
    return (x > 31) ? 31 : x;
  endfunction

  function automatic logic [31:0] mkf(bit ex, bit hb, bit sy, int rca, bit dv, bit sv,
                                      int swo, bit fd, bit ev, int ebo, int txc);
    logic [31:0] w;
    w = '0;
    w[31] = ex; w[30] = hb; w[29] = sy; w[28:24] = 5'(rca);
    w[21] = dv; w[20] = sv; w[19:16] = 4'(swo); w[15] = fd; w[14] = ev;
    w[13:8] = 6'(ebo); w[5:1] = 5'(txc);
    w[0] = ~^w[31:1];
    return w;
  endfunction

  task automatic add_frame(int len, bit drop);
    q_len[q_n] = len; q_drop[q_n] = drop; q_n++;
  endtask

  task automatic drive_src(int b);
    if (b >= avail_from && q_h < q_n) begin
      in_valid = 1; in_data = pat(q_h, q_i);
      in_sof = (q_i == 0); in_eof = (q_i == q_len[q_h] - 1); in_drop = q_drop[q_h];
    end else begin
      in_valid = 0; in_data = 8'h00; in_sof = 0; in_eof = 0; in_drop = 0;
    end
  endtask

  task automatic run_chunk(bit norx, bit perr);
    logic r;
    @(negedge clk);
    hdr_valid = 1; hdr_norx = norx; hdr_perr = perr;
    @(negedge clk);
    hdr_valid = 0; hdr_norx = 0; hdr_perr = 0;
    cons = 0;
    for (int b = 0; b < PAY + 4; b++) begin
      if (b > 0) @(negedge clk);
      drive_src(b);
      out_next = 1;
      #1;
      cb[b] = out_data;
      r = in_ready;
      @(posedge clk);
      if (r) begin
        cons++; q_i++;
        if (q_i == q_len[q_h]) begin q_h++; q_i = 0; end
      end
    end
    @(negedge clk);
    out_next = 0; in_valid = 0; in_sof = 0; in_eof = 0; in_drop = 0; in_data = 8'h00;
    foot = {cb[PAY], cb[PAY+1], cb[PAY+2], cb[PAY+3]};
  endtask

  task automatic chk_foot(logic [31:0] e);
    chk("R1 busy low after chunk", int'(chunk_busy), 0);
    chk("R2 data valid bit", int'(foot[21]), int'(e[21]));
    chk("R4 start flag/offset", int'(foot[20:16]), int'(e[20:16]));
    chk("R5 end flag/offset", int'(foot[14:8]), int'(e[14:8]));
    chk("R6 drop bit", int'(foot[15]), int'(e[15]));
    chk("R7 pending field", int'(foot[28:24]), int'(e[28:24]));
    chk("R7 credit field", int'(foot[5:1]), int'(e[5:1]));
    chk("R8 status bits", int'(foot[31:29]), int'(e[31:29]));
    chk("R8 zero bits", int'({foot[23:22], foot[7:6]}), 0);
    chk("R8 odd parity", int'(^foot), 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int w, mism, nch, fid;
    repeat (3) @(negedge clk);
    chk("R10 irq after reset", int'(irq), 0);
    chk("R10 busy after reset", int'(chunk_busy), 0);
    chk("R10 in_ready after reset", int'(in_ready), 0);
    chk("R10 out_data after reset", int'(out_data), 0);
    rst_n = 1;
    @(negedge clk);

    // length sweep: one frame per run, then one empty chunk
    for (int L = 1; L <= 40; L++) begin
      bit drop, pe;
      drop = (L % 3 == 0); pe = (L % 5 == 0);
      rx_pend = CW'(L); tx_free = CW'(L * 7); ext_st = L[0]; sync_f = L[1];
      fid = q_n;
      add_frame(L, drop);
      nch = (L - 1) / PAY + 1;
      for (int k = 0; k <= nch; k++) begin
        bit last, has;
        run_chunk(0, pe);
        last = (k == nch - 1); has = (k < nch);
        mism = 0;
        for (int i = 0; i < PAY; i++) begin
          logic [7:0] eb;
          eb = (k * PAY + i < L) ? pat(fid, k * PAY + i) : 8'h00;
          if (cb[i] !== eb) mism++;
        end
        chk("R2 payload bytes", mism, 0);
        chk_foot(mkf(L[0], pe, L[1], sat(L), has, (k == 0), 0, last && drop,
                     last, last ? (L - 1) % PAY : 0, sat((L * 7) % 256)));
      end
    end

    // late data: start lands on the next word boundary
    rx_pend = 0; tx_free = 3; ext_st = 0; sync_f = 0;
    for (int d = 0; d < PAY; d++) begin
      fid = q_n;
      add_frame(2, 0);
      avail_from = d;
      run_chunk(0, 0);
      avail_from = 0;
      w = (d + 3) / 4;
      if (w * 4 < PAY) begin
        chk_foot(mkf(0, 0, 0, 0, 1, 1, w, 0, 1, w * 4 + 1, 3));
        chk("R4 first byte at word start", int'(cb[w * 4]), int'(pat(fid, 0)));
      end else begin
        chk_foot(mkf(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3));
        run_chunk(0, 0);
        chk_foot(mkf(0, 0, 0, 0, 1, 1, 0, 0, 1, 1, 3));
      end
    end

    // no-receive header
    fid = q_n;
    add_frame(5, 1);
    run_chunk(1, 0);
    chk("R3 no byte consumed", cons, 0);
    mism = 0;
    for (int i = 0; i < PAY; i++) if (cb[i] !== 8'h00) mism++;
    chk("R3 payload zero", mism, 0);
    chk("R3 data valid clear", int'(foot[21]), 0);
    run_chunk(0, 0);
    chk_foot(mkf(0, 0, 0, 0, 1, 1, 0, 1, 1, 4, 3));
    chk("R3 frame sent later", int'(cb[0]), int'(pat(fid, 0)));

    // back-to-back frames: no start after an end in one chunk
    add_frame(20, 0);
    add_frame(3, 0);
    run_chunk(0, 0);
    chk_foot(mkf(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 3));
    run_chunk(0, 0);
    chk_foot(mkf(0, 0, 0, 0, 1, 0, 0, 0, 1, 3, 3));
    chk("R4 no start after end", int'(cb[4]), 0);
    run_chunk(0, 0);
    chk_foot(mkf(0, 0, 0, 0, 1, 1, 0, 0, 1, 2, 3));

    // interrupt rules
    rx_pend = 0; tx_free = 0; ext_st = 0;
    run_chunk(0, 0);
    chk("R9 irq low after header", int'(irq), 0);
    rx_pend = 2;
    @(negedge clk);
    chk("R9 irq on pending rise", int'(irq), 1);
    run_chunk(0, 0);
    chk("R9 irq cleared by header", int'(irq), 0);
    tx_free = 4;
    @(negedge clk);
    chk("R9 irq on credit rise", int'(irq), 1);
    run_chunk(0, 0);
    chk("R9 irq cleared again", int'(irq), 0);
    rx_pend = 5;
    @(negedge clk);
    chk("R9 no irq when last footer nonzero", int'(irq), 0);
    ext_st = 1;
    @(negedge clk);
    chk("R9 irq on status rise", int'(irq), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule